// File: doc/BRIEF.md
# PCI Memory Initiator with Claim Timeout

This block is the initiator side of a 32-bit PCI bus interface. The local side hands it one request: a direction, a start address, and up to a parameterised number of data beats, each with its own write data and byte enables. The block starts the transaction only after it sees an idle bus cycle. It then drives the address phase and the data phases, and watches DEVSEL, TRDY and STOP from the target. When the transaction ends it reports a one-cycle completion with a status code and the number of beats moved.

If no target claims the cycle within a fixed window after the address phase, the block ends the transaction on its own with a master abort. A target that asserts STOP ends the burst early. PAR is generated for every phase whose AD lines the block drives.

Each bus signal is modelled as a value output plus a drive-enable output, so the chip's pads can implement the shared, tri-stated lines. The block also reads back the resolved FRAME, IRDY and AD values.

Top module: `pci_initiator`

## Requirements
- R1: A request is taken only while the block is idle and the sampled bus shows FRAME and IRDY both high. In the next cycle (the address phase) FRAME is driven low, AD carries the address and C/BE carries 4'b0110 for a read or 4'b0111 for a write. IRDY is not driven in the address phase.
- R2: In every data phase IRDY is driven low and C/BE carries the inverse of the current beat's enable mask (enable bit i set means lane i is used). The value stays the same until that beat transfers. On writes AD carries the beat's data even when all enables are off. On reads AD is not driven.
- R3: FRAME is high in the final data phase while IRDY stays low. IRDY rises only after FRAME was high in the previous cycle. The cycle after the last phase completes drives FRAME and IRDY high and releases AD and C/BE. The cycle after that drives nothing.
- R4: A beat transfers at an edge where DEVSEL and TRDY are both sampled low. For a read, the sampled AD is presented on rd_data with its beat index, and rd_valid is high for the one following cycle.
- R5: If DEVSEL is not sampled low on any of the four edges after the address phase, the transaction ends with master abort (status 1). If FRAME is still low at that point, there is one cycle with FRAME high and IRDY low before the release cycle. If FRAME is already high, the release cycle follows at once.
- R6: STOP sampled low together with DEVSEL makes the next phase the final one. If fewer beats moved than requested, the status is 2 (disconnect). If all beats moved, the status is 0.
- R7: PAR is driven exactly in the cycles after a cycle in which the block drove AD. Its value is the XOR of that previous cycle's 32 AD bits and 4 C/BE bits, so the 37 bits have even parity.
- R8: done is high for exactly the release cycle. In that cycle done_status gives 0 (normal), 1 (master abort) or 2 (disconnect), and done_beats gives the number of beats transferred.
- R9: After reset the block drives no bus signal and does not assert done, rd_valid or PAR, and req_ready is high while the bus is idle.
- R10: While another agent holds FRAME or IRDY low, req_ready is low, a pending request is not taken, and no bus signal is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = memory write, 0 = memory read |
| req_addr | input | 32 | Start address |
| req_last | input | BIDX_W | Index of the last beat (beats minus one) |
| req_wdata | input | MAX_BEATS*32 | Write data, beat i at bits i*32 and up |
| req_be | input | MAX_BEATS*4 | Active-high lane enables, beat i at bits i*4 and up |
| done | output | 1 | Completion pulse |
| done_status | output | 2 | 0 normal, 1 master abort, 2 disconnect |
| done_beats | output | CNT_W | Beats transferred |
| rd_valid | output | 1 | Read beat presented |
| rd_idx | output | BIDX_W | Index of the read beat |
| rd_data | output | 32 | Read beat data |
| frame_n_i | input | 1 | Resolved FRAME line |
| irdy_n_i | input | 1 | Resolved IRDY line |
| devsel_n_i | input | 1 | DEVSEL from target |
| trdy_n_i | input | 1 | TRDY from target |
| stop_n_i | input | 1 | STOP from target |
| ad_i | input | 32 | Resolved AD lines |
| frame_n_o | output | 1 | FRAME value |
| frame_oe | output | 1 | FRAME drive enable |
| irdy_n_o | output | 1 | IRDY value |
| irdy_oe | output | 1 | IRDY drive enable |
| ad_o | output | 32 | AD value |
| ad_oe | output | 1 | AD drive enable |
| cbe_n_o | output | 4 | C/BE value |
| cbe_oe | output | 1 | C/BE drive enable |
| par_o | output | 1 | PAR value |
| par_oe | output | 1 | PAR drive enable |

## Verification
The address phase appears in the cycle after the edge that takes the request, and each data phase's outputs appear in the cycle after the edge that ends the previous phase. The bench's cycle model predicts FRAME, IRDY, AD and C/BE for every cycle. It samples them at the falling edge, after the rising edge that updated them, and drives the target's responses in that same falling-edge slot for the next rising edge. rd_valid, done and PAR are each due exactly one cycle after the edge that produces them: the transfer edge, the completing edge, and the cycle whose AD they cover. The bench therefore compares them against values it stored one falling edge earlier. The master-abort check relies on counting exactly four sampling edges after the address phase.

// File: rtl/pci_init_pkg.sv
package pci_init_pkg;

    localparam int PCI_AD_W = 32;
    localparam int PCI_BE_W = PCI_AD_W / 8;

    localparam logic [PCI_BE_W-1:0] CMD_MEM_READ  = 4'b0110;
    localparam logic [PCI_BE_W-1:0] CMD_MEM_WRITE = 4'b0111;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_DATA,
        PH_RELEASE
    } phase_e;

    typedef enum logic [1:0] {
        ST_OK     = 2'd0,
        ST_MABORT = 2'd1,
        ST_DISC   = 2'd2
    } xfer_status_e;

    typedef struct packed {
        logic                frame_n;
        logic                frame_oe;
        logic                irdy_n;
        logic                irdy_oe;
        logic [PCI_AD_W-1:0] ad;
        logic                ad_oe;
        logic [PCI_BE_W-1:0] cbe_n;
        logic                cbe_oe;
    } bus_drv_t;

    typedef struct packed {
        logic devsel_n;
        logic trdy_n;
        logic stop_n;
    } tgt_resp_t;

    function automatic logic even_par(input logic [PCI_AD_W-1:0] ad,
                                      input logic [PCI_BE_W-1:0] cbe);
        return ^{ad, cbe};
    endfunction

endpackage

// File: rtl/pci_init_seq.sv
module pci_init_seq
    import pci_init_pkg::*;
#(
    parameter int MAX_BEATS   = 4,
    parameter int DEVSEL_WAIT = 4,
    parameter int BIDX_W      = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1,
    parameter int CNT_W       = $clog2(MAX_BEATS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BIDX_W-1:0] last_idx,
    input  tgt_resp_t         resp,
    output phase_e            phase,
    output logic [BIDX_W-1:0] beat,
    output logic              final_ph,
    output logic              xfer,
    output logic              done,
    output xfer_status_e      status,
    output logic [CNT_W-1:0]  beats
);

    localparam int WAIT_W = $clog2(DEVSEL_WAIT + 2);

    phase_e            phase_q;
    xfer_status_e      status_q;
    logic [CNT_W-1:0]  beats_q;
    logic [WAIT_W-1:0] wait_q;
    logic              claimed_q;
    logic              force_q;
    logic              aborting_q;

    logic              claim_now;
    logic              phase_end;
    logic              timeout;
    logic [CNT_W-1:0]  beats_next;
    logic [CNT_W-1:0]  total;

    assign beat       = beats_q[BIDX_W-1:0];
    assign final_ph   = (beat == last_idx) | force_q | aborting_q;
    assign claim_now  = ~resp.devsel_n;
    assign xfer       = (phase_q == PH_DATA) && !aborting_q && claim_now && !resp.trdy_n;
    assign phase_end  = (phase_q == PH_DATA) &&
                        (aborting_q || (claim_now && final_ph && (!resp.trdy_n || !resp.stop_n)));
    assign timeout    = (phase_q == PH_DATA) && !aborting_q && !claimed_q && !claim_now &&
                        (wait_q == WAIT_W'(DEVSEL_WAIT - 1));
    assign beats_next = beats_q + CNT_W'(xfer);
    assign total      = CNT_W'(last_idx) + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            status_q   <= ST_OK;
            beats_q    <= '0;
            wait_q     <= '0;
            claimed_q  <= 1'b0;
            force_q    <= 1'b0;
            aborting_q <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q    <= PH_ADDR;
                        beats_q    <= '0;
                        wait_q     <= '0;
                        claimed_q  <= 1'b0;
                        force_q    <= 1'b0;
                        aborting_q <= 1'b0;
                    end
                end
                PH_ADDR: phase_q <= PH_DATA;
                PH_DATA: begin
                    if (claim_now) claimed_q <= 1'b1;
                    else if (!claimed_q) wait_q <= wait_q + WAIT_W'(1);
                    if (xfer) beats_q <= beats_next;
                    if (phase_end) begin
                        phase_q  <= PH_RELEASE;
                        status_q <= aborting_q ? ST_MABORT :
                                    (beats_next < total) ? ST_DISC : ST_OK;
                    end else if (timeout) begin
                        if (final_ph) begin
                            phase_q  <= PH_RELEASE;
                            status_q <= ST_MABORT;
                        end else begin
                            aborting_q <= 1'b1;
                        end
                    end else if (claim_now && !resp.stop_n) begin
                        force_q <= 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase  = phase_q;
    assign done   = (phase_q == PH_RELEASE);
    assign status = status_q;
    assign beats  = beats_q;

    a_r5_abort_unclaimed: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RELEASE && status_q == ST_MABORT) |-> !claimed_q);

    a_r5_window_bound: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DATA && !claimed_q && !aborting_q) |-> (wait_q < WAIT_W'(DEVSEL_WAIT)));

    a_r6_stop_final: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DATA && !aborting_q && !resp.devsel_n && !resp.stop_n)
        |=> (phase_q == PH_RELEASE || final_ph));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RELEASE) |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/pci_init_drv.sv
module pci_init_drv
    import pci_init_pkg::*;
#(
    parameter int MAX_BEATS = 4,
    parameter int BIDX_W    = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            start,
    input  logic                            req_write,
    input  logic [PCI_AD_W-1:0]             req_addr,
    input  logic [MAX_BEATS*PCI_AD_W-1:0]   req_wdata,
    input  logic [MAX_BEATS*PCI_BE_W-1:0]   req_be,
    input  phase_e                          phase,
    input  logic [BIDX_W-1:0]               beat,
    input  logic                            final_ph,
    input  logic                            xfer,
    input  logic [PCI_AD_W-1:0]             ad_in,
    output bus_drv_t                        drv,
    output logic                            rd_valid,
    output logic [BIDX_W-1:0]               rd_idx,
    output logic [PCI_AD_W-1:0]             rd_data
);

    logic                wr_q;
    logic [PCI_AD_W-1:0] addr_q;
    logic [PCI_AD_W-1:0] wd_q [MAX_BEATS];
    logic [PCI_BE_W-1:0] be_q [MAX_BEATS];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q   <= 1'b0;
            addr_q <= '0;
        end else if (start) begin
            wr_q   <= req_write;
            addr_q <= req_addr;
        end
    end

    for (genvar i = 0; i < MAX_BEATS; i++) begin : g_beat
        always_ff @(posedge clk) begin
            if (rst) begin
                wd_q[i] <= '0;
                be_q[i] <= '0;
            end else if (start) begin
                wd_q[i] <= req_wdata[i*PCI_AD_W +: PCI_AD_W];
                be_q[i] <= req_be[i*PCI_BE_W +: PCI_BE_W];
            end
        end
    end

    always_comb begin
        drv = '{frame_n: 1'b1, frame_oe: 1'b0, irdy_n: 1'b1, irdy_oe: 1'b0,
                ad: '0, ad_oe: 1'b0, cbe_n: '1, cbe_oe: 1'b0};
        case (phase)
            PH_ADDR: begin
                drv.frame_n  = 1'b0;
                drv.frame_oe = 1'b1;
                drv.ad       = addr_q;
                drv.ad_oe    = 1'b1;
                drv.cbe_n    = wr_q ? CMD_MEM_WRITE : CMD_MEM_READ;
                drv.cbe_oe   = 1'b1;
            end
            PH_DATA: begin
                drv.frame_n  = final_ph;
                drv.frame_oe = 1'b1;
                drv.irdy_n   = 1'b0;
                drv.irdy_oe  = 1'b1;
                drv.ad       = wr_q ? wd_q[beat] : '0;
                drv.ad_oe    = wr_q;
                drv.cbe_n    = ~be_q[beat];
                drv.cbe_oe   = 1'b1;
            end
            PH_RELEASE: begin
                drv.frame_oe = 1'b1;
                drv.irdy_oe  = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_idx   <= '0;
            rd_data  <= '0;
        end else begin
            rd_valid <= xfer && !wr_q;
            if (xfer && !wr_q) begin
                rd_idx  <= beat;
                rd_data <= ad_in;
            end
        end
    end

    a_r2_cbe_held: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA && $past(phase == PH_DATA) && !$past(xfer)) |-> $stable(drv.cbe_n));

endmodule

// File: rtl/pci_init_par.sv
module pci_init_par
    import pci_init_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [PCI_AD_W-1:0] ad,
    input  logic [PCI_BE_W-1:0] cbe_n,
    input  logic                ad_oe,
    output logic                par,
    output logic                par_oe
);

    always_ff @(posedge clk) begin
        if (rst) begin
            par    <= 1'b0;
            par_oe <= 1'b0;
        end else begin
            par    <= even_par(ad, cbe_n);
            par_oe <= ad_oe;
        end
    end

endmodule

// File: rtl/pci_initiator.sv
module pci_initiator
    import pci_init_pkg::*;
#(
    parameter int MAX_BEATS   = 4,
    parameter int DEVSEL_WAIT = 4,
    parameter int BIDX_W      = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1,
    parameter int CNT_W       = $clog2(MAX_BEATS + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic                          req_write,
    input  logic [PCI_AD_W-1:0]           req_addr,
    input  logic [BIDX_W-1:0]             req_last,
    input  logic [MAX_BEATS*PCI_AD_W-1:0] req_wdata,
    input  logic [MAX_BEATS*PCI_BE_W-1:0] req_be,
    output logic                          done,
    output logic [1:0]                    done_status,
    output logic [CNT_W-1:0]              done_beats,
    output logic                          rd_valid,
    output logic [BIDX_W-1:0]             rd_idx,
    output logic [PCI_AD_W-1:0]           rd_data,
    input  logic                          frame_n_i,
    input  logic                          irdy_n_i,
    input  logic                          devsel_n_i,
    input  logic                          trdy_n_i,
    input  logic                          stop_n_i,
    input  logic [PCI_AD_W-1:0]           ad_i,
    output logic                          frame_n_o,
    output logic                          frame_oe,
    output logic                          irdy_n_o,
    output logic                          irdy_oe,
    output logic [PCI_AD_W-1:0]           ad_o,
    output logic                          ad_oe,
    output logic [PCI_BE_W-1:0]           cbe_n_o,
    output logic                          cbe_oe,
    output logic                          par_o,
    output logic                          par_oe
);

    phase_e            phase;
    logic [BIDX_W-1:0] beat;
    logic [BIDX_W-1:0] last_q;
    logic              final_ph;
    logic              xfer;
    logic              start;
    xfer_status_e      status;
    bus_drv_t          drv;
    tgt_resp_t         resp;

    assign req_ready = (phase == PH_IDLE) && frame_n_i && irdy_n_i;
    assign start     = req_valid && req_ready;
    assign resp      = '{devsel_n: devsel_n_i, trdy_n: trdy_n_i, stop_n: stop_n_i};

    always_ff @(posedge clk) begin
        if (rst)        last_q <= '0;
        else if (start) last_q <= req_last;
    end

    pci_init_seq #(
        .MAX_BEATS  (MAX_BEATS),
        .DEVSEL_WAIT(DEVSEL_WAIT),
        .BIDX_W     (BIDX_W),
        .CNT_W      (CNT_W)
    ) seq_i (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .last_idx(last_q),
        .resp    (resp),
        .phase   (phase),
        .beat    (beat),
        .final_ph(final_ph),
        .xfer    (xfer),
        .done    (done),
        .status  (status),
        .beats   (done_beats)
    );

    pci_init_drv #(
        .MAX_BEATS(MAX_BEATS),
        .BIDX_W   (BIDX_W)
    ) drv_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .req_be   (req_be),
        .phase    (phase),
        .beat     (beat),
        .final_ph (final_ph),
        .xfer     (xfer),
        .ad_in    (ad_i),
        .drv      (drv),
        .rd_valid (rd_valid),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data)
    );

    pci_init_par par_i (
        .clk   (clk),
        .rst   (rst),
        .ad    (drv.ad),
        .cbe_n (drv.cbe_n),
        .ad_oe (drv.ad_oe),
        .par   (par_o),
        .par_oe(par_oe)
    );

    assign done_status = status;
    assign frame_n_o   = drv.frame_n;
    assign frame_oe    = drv.frame_oe;
    assign irdy_n_o    = drv.irdy_n;
    assign irdy_oe     = drv.irdy_oe;
    assign ad_o        = drv.ad;
    assign ad_oe       = drv.ad_oe;
    assign cbe_n_o     = drv.cbe_n;
    assign cbe_oe      = drv.cbe_oe;

    a_r1_irdy_free_in_addr: assert property (@(posedge clk) disable iff (rst)
        (frame_oe && !frame_n_o && !$past(frame_oe)) |-> !irdy_oe);

    a_r3_irdy_after_frame: assert property (@(posedge clk) disable iff (rst)
        (irdy_oe && $past(irdy_oe) && irdy_n_o && !$past(irdy_n_o)) |-> $past(frame_n_o));

    a_r10_quiet_when_busy: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && phase == PH_IDLE) |=> !frame_oe);

endmodule

// File: tb/pci_initiator_tb_top.sv
module pci_initiator_tb_top;
    import pci_init_pkg::*;

    localparam int NB = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic              req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [31:0]       req_addr = '0;
    logic [1:0]        req_last = '0;
    logic [NB*32-1:0]  req_wdata = '0;
    logic [NB*4-1:0]   req_be = '0;
    logic              done, rd_valid;
    logic [1:0]        done_status, rd_idx;
    logic [2:0]        done_beats;
    logic [31:0]       rd_data, ad_o, ad_i;
    logic              frame_n_o, frame_oe, irdy_n_o, irdy_oe, ad_oe, cbe_oe, par_o, par_oe;
    logic [3:0]        cbe_n_o;
    logic              ext_frame_n = 1'b1, ext_irdy_n = 1'b1;
    logic              devsel_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1;
    logic [31:0]       ad_tgt = '0;
    logic              frame_bus, irdy_bus;

    assign frame_bus = frame_oe ? frame_n_o : ext_frame_n;
    assign irdy_bus  = irdy_oe ? irdy_n_o : ext_irdy_n;
    assign ad_i      = ad_oe ? ad_o : ad_tgt;

    pci_initiator dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_last(req_last),
        .req_wdata(req_wdata), .req_be(req_be), .done(done), .done_status(done_status),
        .done_beats(done_beats), .rd_valid(rd_valid), .rd_idx(rd_idx), .rd_data(rd_data),
        .frame_n_i(frame_bus), .irdy_n_i(irdy_bus), .devsel_n_i(devsel_n), .trdy_n_i(trdy_n),
        .stop_n_i(stop_n), .ad_i(ad_i), .frame_n_o(frame_n_o), .frame_oe(frame_oe),
        .irdy_n_o(irdy_n_o), .irdy_oe(irdy_oe), .ad_o(ad_o), .ad_oe(ad_oe),
        .cbe_n_o(cbe_n_o), .cbe_oe(cbe_oe), .par_o(par_o), .par_oe(par_oe)
    );

    int n_chk = 0, n_fail = 0;
    bit reported = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
    endtask

    // Reference patterns
    function automatic logic [31:0] wpat(input logic [31:0] a, input int i);
        return a ^ (32'h1111_1111 * (i + 1));
    endfunction
    function automatic logic [31:0] rpat(input logic [31:0] a, input int i);
        return 32'hA500_0000 | (a[15:0] << 4) | i;
    endfunction
    function automatic logic [3:0] bpat(input int i);
        case (i)
            0: return 4'hF;
            1: return 4'h0;
            2: return 4'h5;
            default: return 4'hA;
        endcase
    endfunction

    // R7: parity reference, checked every clock
    logic [31:0] prev_ad = '0;
    logic [3:0]  prev_cbe = '0;
    logic        prev_oe = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            chk("R7 par_oe", par_oe, prev_oe);
            if (prev_oe) chk("R7 par value", par_o, ^{prev_ad, prev_cbe});
        end
        prev_ad  = ad_o;
        prev_cbe = cbe_n_o;
        prev_oe  = ad_oe;
    end

    task automatic run_txn(input bit wr, input logic [31:0] addr, input int nb,
                           input int claim, input int wait1, input int stop_beat,
                           input int exp_status, input int exp_beats);
        int db = 0, k = 0;
        bit fin = 0, abrt = 0, stopping = 0, claimed = 0, rel = 0;
        bit prev_rd = 0;
        int prev_idx = 0;
        logic [31:0] prev_data = '0;
        req_write = wr;
        req_addr  = addr;
        req_last  = 2'(nb - 1);
        for (int i = 0; i < NB; i++) begin
            req_wdata[i*32 +: 32] = wpat(addr, i);
            req_be[i*4 +: 4]      = bpat(i);
        end
        req_valid = 1'b1;
        chk("R1 req_ready idle", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1 addr frame_oe", frame_oe, 1);
        chk("R1 addr frame_n", frame_n_o, 0);
        chk("R1 addr ad", {ad_oe, ad_o}, {1'b1, addr});
        chk("R1 addr cmd", {cbe_oe, cbe_n_o}, {1'b1, wr ? 4'b0111 : 4'b0110});
        chk("R1 addr irdy_oe", irdy_oe, 0);
        @(negedge clk);
        while (!rel) begin
            bit exp_fh, dv, tr, st, xf;
            k++;
            chk("R4 rd_valid", rd_valid, prev_rd);
            if (prev_rd) chk("R4 rd_data", {rd_idx, rd_data}, {2'(prev_idx), prev_data});
            exp_fh = (db == nb - 1) || fin || abrt;
            chk("R3 frame level", {frame_oe, frame_n_o}, {1'b1, exp_fh});
            chk("R2 irdy low", {irdy_oe, irdy_n_o}, 2'b10);
            chk("R2 cbe enables", {cbe_oe, cbe_n_o}, {1'b1, ~bpat(db)});
            chk("R2 ad drive", ad_oe, wr);
            if (wr) chk("R2 write data", ad_o, wpat(addr, db));
            dv = (claim >= 1) && (claim <= 4) && (k >= claim) && !abrt;
            tr = dv && (k >= claim + wait1) && !stopping;
            st = dv && (stopping || (stop_beat == db && tr));
            devsel_n = !dv; trdy_n = !tr; stop_n = !st;
            ad_tgt = tr ? rpat(addr, db) : 32'h0;
            xf = 0;
            if (abrt) rel = 1;
            else if (!dv) begin
                if (k == 4 && !claimed) begin
                    if (exp_fh) rel = 1; else abrt = 1;
                end
            end else begin
                claimed = 1;
                if (tr) xf = 1;
                if (exp_fh && (tr || st)) rel = 1;
                else if (st) begin fin = 1; stopping = 1; end
            end
            prev_rd = xf && !wr;
            prev_idx = db;
            prev_data = rpat(addr, db);
            if (xf) db++;
            @(negedge clk);
        end
        devsel_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1; ad_tgt = '0;
        chk("R4 rd_valid last", rd_valid, prev_rd);
        if (prev_rd) chk("R4 rd_data last", {rd_idx, rd_data}, {2'(prev_idx), prev_data});
        chk("R3 release frame/irdy", {frame_oe, frame_n_o, irdy_oe, irdy_n_o}, 4'b1111);
        chk("R3 release ad/cbe", {ad_oe, cbe_oe}, 2'b00);
        chk("R8 done", done, 1);
        chk("R8 status", done_status, exp_status);
        chk("R8 beats", done_beats, exp_beats);
        chk("R8 beats model", db, exp_beats);
        @(negedge clk);
        chk("R3 idle no drive", {frame_oe, irdy_oe, ad_oe, cbe_oe}, 4'b0000);
        chk("R8 done pulse", done, 0);
        chk("R4 rd_valid idle", rd_valid, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk("R9 no drive", {frame_oe, irdy_oe, ad_oe, cbe_oe, par_oe}, 5'b0);
        chk("R9 no done/rd", {done, rd_valid}, 2'b00);
        chk("R9 ready", req_ready, 1);

        // R10: bus held by another agent
        ext_frame_n = 1'b0; ext_irdy_n = 1'b0;
        req_write = 1'b1; req_addr = 32'h0000_0100; req_last = 2'd0;
        req_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R10 not ready", req_ready, 0);
            chk("R10 no drive", {frame_oe, ad_oe}, 2'b00);
        end
        req_valid = 1'b0;
        ext_frame_n = 1'b1; ext_irdy_n = 1'b1;
        @(negedge clk);
        chk("R10 request dropped", frame_oe, 0);

        // wr 4 beats, fast claim (includes a zero-enable lane, R2)
        run_txn(1, 32'h1000_0040, 4, 1, 0, -1, 0, 4);
        // rd 3 beats, medium claim, two wait states (R4)
        run_txn(0, 32'h2000_1230, 3, 2, 2, -1, 0, 3);
        // wr 1 beat, claim on the last allowed edge (R5 boundary)
        run_txn(1, 32'h3000_0008, 1, 4, 0, -1, 0, 1);
        // rd 2 beats, nobody claims: master abort with extra phase (R5)
        run_txn(0, 32'h4000_0000, 2, 0, 0, -1, 1, 0);
        // rd 1 beat, nobody claims: straight to release (R5)
        run_txn(0, 32'h5000_0010, 1, 0, 0, -1, 1, 0);
        // wr 4 beats, stop on beat 1: disconnect (R6)
        run_txn(1, 32'h6000_0020, 4, 1, 0, 1, 2, 2);
        // wr 2 beats, stop on last beat: normal (R6)
        run_txn(1, 32'h7000_0030, 2, 3, 1, 1, 0, 2);
        // rd 4 beats, stop on beat 0 (R6, R4)
        run_txn(0, 32'h8000_0400, 4, 1, 0, 0, 2, 1);

        report();
        $finish;
    end

endmodule